// File: doc/BRIEF.md
# Non-Volatile Memory Access Guard

This block sits between the transaction decoder of a serial bus and the write engine of a small non-volatile memory model. It decides whether a bus transaction may touch the memory, and whether a write request may start an internal programming cycle. A supervisor reset flag, a write-protect pin and the busy state of the write path are the conditions it weighs.

When the supervisor reset rises during an open transaction, the guard issues a one-cycle abort pulse and closes the transaction. While that reset holds, the guard refuses every transaction and every write. After the reset clears, a transaction opens only on a fresh start strobe. A programming cycle that is already running is never cut short. A down-counter models its fixed length, and the counter keeps running through reset. The write-protect pin refuses writes but leaves reads alone. A write request that arrives while the write path is busy is refused, and a separate flag reports that refusal.

Top module: `nvm_access_guard`

## Requirements
- R1: While `sup_rst` is high, `txn_ok` is low, so no read or write transaction is allowed.
- R2: `txn_abort` pulses high for exactly one cycle in the first cycle `sup_rst` is high, and only if a transaction was open in that cycle; with no open transaction there is no pulse.
- R3: `wr_start` is never high in a cycle where `sup_rst` is high.
- R4: A programming cycle in progress keeps `wcyc_busy` high to its full length even if `sup_rst` rises during it.
- R5: After a `wr_start` pulse, `wcyc_busy` is high for exactly `WR_CYCLES` cycles, beginning in the following cycle.
- R6: While `wp` is high, `wr_start` stays low; `wp` has no effect on `txn_ok`, so reads stay allowed.
- R7: A write request with `txn_ok` high, `wp` low and the write path busy (`wcyc_busy` or `eng_busy`) raises `wr_busy_rej` in that same cycle and no `wr_start`.
- R8: After `sup_rst` falls, `txn_ok` stays low until a `txn_start` is seen with `sup_rst` low. A start strobe seen during reset is dropped.
- R9: A `txn_start` with `sup_rst` low opens a transaction, and `txn_ok` is high from the next cycle. A `txn_stop` closes it, and `txn_ok` is low from the next cycle. If both strobes arrive in the same cycle, the start wins (default `START_WINS=1`).
- R10: `wr_start` is high in the same cycle as `wr_req` exactly when `txn_ok` is high, `wp` is low and the write path is not busy.
- R11: While `rst_n` is low, the transaction is closed and the programming counter is cleared, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous logic reset |
| sup_rst | input | 1 | Supervisor reset-active flag |
| wp | input | 1 | Write-protect pin, high refuses writes |
| txn_start | input | 1 | Bus transaction start strobe |
| txn_stop | input | 1 | Bus transaction stop strobe |
| wr_req | input | 1 | Write request strobe from the decoder |
| eng_busy | input | 1 | Busy flag from the external write engine |
| txn_abort | output | 1 | One-cycle abort pulse for the open transaction |
| txn_ok | output | 1 | Transaction allowed flag |
| wr_start | output | 1 | Start enable for a programming cycle |
| wr_busy_rej | output | 1 | Write refused because the write path is busy |
| wcyc_busy | output | 1 | Modelled programming cycle in progress |

## Verification
Some rules hold on every clock, and the bound checker tests them there. These are the reset blocking of transactions and writes, the write-protect block, the single-cycle abort, the mutual exclusion of grant and busy refusal, the exact length of the programming window (counted by the checker) and the rule that `txn_ok` cannot rise without a start strobe. Other behaviour shows up only in the bench's scenarios, where its cycle-level reference model is compared on every clock. That covers whether an abort fires only when a transaction was really open, whether a programming cycle runs on across a reset that arrives midway, whether a start strobe given during reset is dropped, and the same-cycle start and stop priority.

// File: rtl/nag_pkg.sv
package nag_pkg;
   // Decision of the write gate for one cycle
   typedef enum logic [1:0] {
      WG_IDLE  = 2'd0,
      WG_GRANT = 2'd1,
      WG_BUSY  = 2'd2,
      WG_DENY  = 2'd3
   } wg_dec_e;
endpackage

// File: rtl/nag_session.sv
// Tracks whether a bus transaction is open and raises the abort pulse.
module nag_session #(
   parameter bit START_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_rst,
   input  logic start_i,
   input  logic stop_i,
   output logic ok_o,
   output logic abort_o
);
   logic open_q;
   logic open_d;

   generate
      if (START_WINS) begin : g_start_prio
         always_comb begin
            if (start_i)     open_d = 1'b1;
            else if (stop_i) open_d = 1'b0;
            else             open_d = open_q;
         end
      end else begin : g_stop_prio
         always_comb begin
            if (stop_i)       open_d = 1'b0;
            else if (start_i) open_d = 1'b1;
            else              open_d = open_q;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       open_q <= 1'b0;
      else if (sup_rst) open_q <= 1'b0;   // close and refuse new starts
      else              open_q <= open_d;
   end

   // open_q clears one cycle after reset rises, so this is a single pulse
   assign abort_o = sup_rst & open_q;
   assign ok_o    = open_q & ~sup_rst;
endmodule

// File: rtl/nag_wcyc_timer.sv
// Models the fixed length of an internal programming cycle.
module nag_wcyc_timer #(
   parameter int unsigned WR_CYCLES = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic busy_o
);
   localparam int unsigned CW = $clog2(WR_CYCLES + 1);

   generate
      if (WR_CYCLES < 1) begin : g_bad_len
         $error("nag_wcyc_timer: WR_CYCLES must be at least 1");
      end
   endgenerate

   logic [CW-1:0] left_q;

   // No supervisor reset input: a running cycle always completes
   always_ff @(posedge clk) begin
      if (!rst_n)              left_q <= '0;
      else if (load_i)         left_q <= CW'(WR_CYCLES);
      else if (left_q != '0)   left_q <= left_q - CW'(1);
   end

   assign busy_o = (left_q != '0);
endmodule

// File: rtl/nag_write_gate.sv
// Combinational decision on a write request.
module nag_write_gate
   import nag_pkg::*;
(
   input  logic    wr_req_i,
   input  logic    ok_i,
   input  logic    wp_i,
   input  logic    busy_i,
   output wg_dec_e dec_o
);
   always_comb begin
      if (!wr_req_i)         dec_o = WG_IDLE;
      else if (!ok_i || wp_i) dec_o = WG_DENY;
      else if (busy_i)       dec_o = WG_BUSY;
      else                   dec_o = WG_GRANT;
   end
endmodule

// File: rtl/nvm_access_guard.sv
module nvm_access_guard
   import nag_pkg::*;
#(
   parameter int unsigned WR_CYCLES  = 500000,
   parameter bit          START_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sup_rst,
   input  logic wp,
   input  logic txn_start,
   input  logic txn_stop,
   input  logic wr_req,
   input  logic eng_busy,
   output logic txn_abort,
   output logic txn_ok,
   output logic wr_start,
   output logic wr_busy_rej,
   output logic wcyc_busy
);
   logic    ok_w;
   logic    timer_busy;
   wg_dec_e dec;

   nag_session #(.START_WINS(START_WINS)) u_session (
      .clk     (clk),
      .rst_n   (rst_n),
      .sup_rst (sup_rst),
      .start_i (txn_start),
      .stop_i  (txn_stop),
      .ok_o    (ok_w),
      .abort_o (txn_abort)
   );

   nag_write_gate u_gate (
      .wr_req_i (wr_req),
      .ok_i     (ok_w),
      .wp_i     (wp),
      .busy_i   (timer_busy | eng_busy),
      .dec_o    (dec)
   );

   nag_wcyc_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (wr_start),
      .busy_o (timer_busy)
   );

   assign txn_ok      = ok_w;
   assign wr_start    = (dec == WG_GRANT);
   assign wr_busy_rej = (dec == WG_BUSY);
   assign wcyc_busy   = timer_busy;
endmodule

// File: rtl/nag_checker.sv
module nag_checker #(
   parameter int unsigned WR_CYCLES = 500000
) (
   input logic clk,
   input logic rst_n,
   input logic sup_rst,
   input logic wp,
   input logic txn_start,
   input logic txn_abort,
   input logic txn_ok,
   input logic wr_start,
   input logic wr_busy_rej,
   input logic wcyc_busy
);
   // Independent count of the programming window
   int unsigned chk_left;
   always_ff @(posedge clk) begin
      if (!rst_n)          chk_left <= 0;
      else if (wr_start)   chk_left <= WR_CYCLES;
      else if (chk_left != 0) chk_left <= chk_left - 1;
   end

   p_no_txn_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      sup_rst |-> !txn_ok);
   p_abort_needs_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
      txn_abort |-> sup_rst);
   p_abort_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      txn_abort |=> !txn_abort);
   p_no_write_in_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sup_rst |-> !wr_start);
   p_cycle_survives_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wcyc_busy && chk_left > 1) |=> wcyc_busy);
   p_cycle_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wcyc_busy == (chk_left != 0));
   p_wp_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wp |-> !wr_start);
   p_busy_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_start, wr_busy_rej}));
   p_no_grant_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wcyc_busy |-> !wr_start);
   p_fresh_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!txn_ok && !txn_start) |=> !txn_ok);
endmodule

bind nvm_access_guard nag_checker #(.WR_CYCLES(WR_CYCLES)) u_nag_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sup_rst     (sup_rst),
   .wp          (wp),
   .txn_start   (txn_start),
   .txn_abort   (txn_abort),
   .txn_ok      (txn_ok),
   .wr_start    (wr_start),
   .wr_busy_rej (wr_busy_rej),
   .wcyc_busy   (wcyc_busy)
);

// File: tb/nvm_access_guard_bench.sv
module nvm_access_guard_bench;
   localparam int WR = 12;

   logic clk = 1'b0;
   logic rst_n, sup_rst, wp, txn_start, txn_stop, wr_req, eng_busy;
   logic txn_abort, txn_ok, wr_start, wr_busy_rej, wcyc_busy;

   always #5 clk = ~clk;   // 100 MHz

   nvm_access_guard #(.WR_CYCLES(WR), .START_WINS(1'b1)) u_nvm_access_guard (
      .clk(clk), .rst_n(rst_n), .sup_rst(sup_rst), .wp(wp),
      .txn_start(txn_start), .txn_stop(txn_stop), .wr_req(wr_req),
      .eng_busy(eng_busy), .txn_abort(txn_abort), .txn_ok(txn_ok),
      .wr_start(wr_start), .wr_busy_rej(wr_busy_rej), .wcyc_busy(wcyc_busy)
   );

   int vectors = 0;
   int miscompares = 0;
   string tag = "R11";
   bit done = 1'b0;

   // Behavioural reference state
   bit m_open = 0;
   int m_left = 0;

   task automatic chk(input string name, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, name, act, exp, $time);
      end
   endtask

   // One clock: drive at the negedge, compare, then advance the model at the posedge
   task automatic cyc(input bit s, input bit w, input bit st, input bit sp,
                      input bit rq, input bit eb);
      bit e_ok, e_busy, e_wrs, e_rej, e_ab;
      sup_rst = s; wp = w; txn_start = st; txn_stop = sp; wr_req = rq; eng_busy = eb;
      #1;
      e_ok   = m_open && !s;
      e_ab   = s && m_open;
      e_busy = (m_left > 0) || eb;
      e_wrs  = rq && e_ok && !w && !e_busy;
      e_rej  = rq && e_ok && !w && e_busy;
      chk("txn_ok", txn_ok, e_ok);
      chk("txn_abort", txn_abort, e_ab);
      chk("wr_start", wr_start, e_wrs);
      chk("wr_busy_rej", wr_busy_rej, e_rej);
      chk("wcyc_busy", wcyc_busy, m_left > 0);
      @(posedge clk);
      if (e_wrs) m_left = WR;
      else if (m_left > 0) m_left--;
      if (s) m_open = 0;
      else if (st) m_open = 1;
      else if (sp) m_open = 0;
      @(negedge clk);
   endtask

   task automatic idle(input int n, input bit s);
      for (int i = 0; i < n; i++) cyc(s, 0, 0, 0, 0, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      rst_n = 0; sup_rst = 0; wp = 0; txn_start = 0; txn_stop = 0; wr_req = 0; eng_busy = 0;
      repeat (3) @(negedge clk);
      // R11: outputs low during logic reset, even with strobes driven
      tag = "R11";
      txn_start = 1; wr_req = 1;
      #1;
      chk("txn_ok", txn_ok, 0); chk("wr_start", wr_start, 0);
      chk("wcyc_busy", wcyc_busy, 0); chk("txn_abort", txn_abort, 0);
      @(negedge clk);
      rst_n = 1; m_open = 0; m_left = 0;

      // R9 R10 R5: open, write, count the window
      tag = "R9";  cyc(0,0,1,0,0,0); idle(1,0);
      tag = "R10"; cyc(0,0,0,0,1,0);
      tag = "R5";  idle(WR + 3, 0);
      // R7: refusal while own cycle runs and while engine is busy
      tag = "R7";  cyc(0,0,0,0,1,0); cyc(0,0,0,0,1,0); idle(WR, 0);
      cyc(0,0,0,0,1,1); cyc(0,0,0,0,0,1);
      // R6: write protect refuses writes, txn_ok unaffected
      tag = "R6";  cyc(0,1,0,0,1,0); cyc(0,1,0,0,1,0); cyc(0,1,0,0,0,0);
      // R9: stop closes
      tag = "R9";  cyc(0,0,0,1,0,0); idle(2,0);
      // R2 R1 R3: reset during open transaction aborts once
      tag = "R2";  cyc(0,0,1,0,0,0); cyc(0,0,0,0,0,0);
      cyc(1,0,0,0,1,0); cyc(1,0,0,0,1,0);
      tag = "R1";  idle(2,1);
      tag = "R3";  cyc(1,0,1,0,1,0); cyc(1,0,0,0,1,0);
      // R8: start in reset dropped; after release still closed until fresh start
      tag = "R8";  idle(3,0); cyc(0,0,1,0,0,0); idle(2,0);
      // R4: cycle in progress survives reset
      tag = "R4";  cyc(0,0,0,0,1,0); idle(3,0); idle(4,1); idle(WR,0);
      // R2: reset rising with no transaction open: no abort
      tag = "R2";  cyc(0,0,0,1,0,0); idle(1,0); idle(3,1); idle(2,0);
      // R9: start and stop together, start wins
      tag = "R9";  cyc(0,0,1,1,0,0); idle(2,0); cyc(0,0,1,1,0,0); idle(1,0);
      // Mixed traffic against the model
      tag = "R10";
      for (int i = 0; i < 3000; i++) begin
         cyc(($urandom % 12) == 0, ($urandom % 6) == 0, ($urandom % 5) == 0,
             ($urandom % 7) == 0, ($urandom % 3) == 0, ($urandom % 9) == 0);
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule